// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard

This block is the hazard-tracking controller that sits between in-order instruction decode and a set of functional units. Each cycle it may take one decoded instruction, made of an operation class, a destination register and two source registers. It admits that instruction to the unit that serves its class only when that unit is free and no instruction already in flight will write the same destination register. After admission, each unit moves through its own life cycle. It waits for its operands to become valid and then receives a one-cycle read grant. It executes until its datapath pulses `ex_done`. It then waits until no other unit still has to read the old contents of its destination, and only then receives a writeback grant.

The scoreboard holds two kinds of state. One is a per-unit status record: the destination, the two sources, a producer tag for each source and a ready flag for each source. The other is a per-register table that names the unit which will write each register. Tags run from 1 to `NUM_UNITS`, and tag 0 means no write is pending. A writeback wakes every waiting consumer of that tag. Because of this, read-after-write hazards delay only operand reads and write-after-read hazards delay only writebacks. Structural and write-after-write conflicts stall issue. Issue is strictly in program order, while reads and writebacks can complete out of order.

Each unit is controlled by a four-state machine:
- `U_IDLE`: the unit is free.
- `U_WAIT_OPS`: the unit is waiting for its source operands.
- `U_EXEC`: the unit's datapath is executing.
- `U_DONE`: execution is finished and the unit is waiting for its writeback.

The transitions are:
- T_ISSUE: `U_IDLE` to `U_WAIT_OPS`, when the instruction is accepted.
- T_READ: `U_WAIT_OPS` to `U_EXEC`, when the read grant is given.
- T_FINISH: `U_EXEC` to `U_DONE`, on the unit's `ex_done` pulse.
- T_RETIRE: `U_DONE` to `U_IDLE`, on the writeback grant.

Every other condition holds the current state.

Top module: `ooo_scoreboard`

## Requirements
- R1: `iss_accept` is high in the same cycle exactly when `iss_valid` is high, the unit chosen by `iss_op` is not busy, and no unit has a pending write to `iss_dst`. A busy unit (structural conflict) or a pending writer of the destination (WAW conflict) holds `iss_accept` low.
- R2: Operation class k is always executed by unit k, and the producer tag of unit k is k+1. `rd_grant` and `wb_grant` bit k belong to unit k.
- R3: At issue, a source becomes ready if no unit is pending a write to it. It also becomes ready if its pending writer is being granted writeback in that same cycle.
- R4: `rd_grant[k]` is high for exactly one cycle, in the first cycle in which unit k is waiting for operands with both sources ready. Both ready flags then clear.
- R5: A unit becomes eligible for writeback only after an `ex_done[k]` pulse that arrives while it is executing. A pulse in any other state is ignored.
- R6: A finished unit is held from writeback while any other unit has a source equal to its destination with that source's ready flag still set.
- R7: At most one writeback is granted per cycle, and the lowest-indexed eligible unit wins. `wb_valid` is high with the one-hot `wb_grant`, and `wb_dst` carries the granted unit's destination in the same cycle.
- R8: A writeback by tag t sets the ready flag of every waiting source whose producer is t. The waking unit receives its read grant in the next cycle.
- R9: A writeback frees the writing unit and clears the pending-writer entry of its destination. From the next cycle, both that unit and that destination are available to issue.
- R10: A synchronous active-high `rst` returns every unit to idle and clears all ready flags, tags and pending-writer entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_op | input | OPW | Operation class; selects the unit |
| iss_dst | input | REGW | Destination register |
| iss_src1 | input | REGW | First source register |
| iss_src2 | input | REGW | Second source register |
| ex_done | input | NUM_UNITS | Per-unit execution-complete pulse |
| iss_accept | output | 1 | Instruction admitted this cycle |
| rd_grant | output | NUM_UNITS | Per-unit operand-read grant |
| wb_valid | output | 1 | A writeback is granted this cycle |
| wb_grant | output | NUM_UNITS | One-hot writeback grant |
| wb_dst | output | REGW | Destination register of the granted writeback |

## Verification
The main sequence tries issue in four situations: with every resource free, with the target unit busy, with the destination already owned by another unit, and with a source whose producer writes back in that same cycle. Each of these pins down one term of the issue condition or the wake-up bypass. A consumer that waits on a producer shows that operand reads depend only on RAW readiness. A finished unit whose destination is still an unread source of a waiting unit shows that writebacks depend only on WAR clearance. Two units finishing together separate the fixed priority from arrival order. Directed cases then show that a mid-flight reset frees everything, and that a done pulse sent to a unit still waiting for its operands leaves it unable to write back.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Life cycle of one functional-unit status record
    typedef enum logic [1:0] {
        U_IDLE     = 2'd0,
        U_WAIT_OPS = 2'd1,
        U_EXEC     = 2'd2,
        U_DONE     = 2'd3
    } unit_state_e;

endpackage

// File: rtl/sb_result_table.sv
module sb_result_table #(
    parameter int NUM_REGS = 8,
    parameter int TAGW     = 3,
    localparam int REGW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [REGW-1:0] set_idx,
    input  logic [TAGW-1:0] set_tag,
    input  logic            clr_en,
    input  logic [REGW-1:0] clr_idx,
    input  logic [REGW-1:0] rd_idx_a,
    input  logic [REGW-1:0] rd_idx_b,
    input  logic [REGW-1:0] rd_idx_d,
    output logic [TAGW-1:0] rd_tag_a,
    output logic [TAGW-1:0] rd_tag_b,
    output logic [TAGW-1:0] rd_tag_d
);

    // Pending-writer tag per register; zero means nobody will write it
    logic [TAGW-1:0] owner [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                owner[i] <= '0;
            end
        end else begin
            if (clr_en) begin
                owner[clr_idx] <= '0;
            end
            if (set_en) begin
                owner[set_idx] <= set_tag;
            end
        end
    end

    always_comb begin
        rd_tag_a = owner[rd_idx_a];
        rd_tag_b = owner[rd_idx_b];
        rd_tag_d = owner[rd_idx_d];
    end

    // A new owner is only recorded for an unowned register
    AST_NO_DOUBLE_WRITER: assert property (@(posedge clk) disable iff (rst)
        set_en |-> (owner[set_idx] == '0)); // R1

    // A writeback always releases a register that had an owner
    AST_CLEAR_OWNED: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> (owner[clr_idx] != '0)); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> (owner[$past(clr_idx)] == '0)); // R9

endmodule

// File: rtl/sb_unit.sv
module sb_unit
    import sb_pkg::*;
#(
    parameter int REGW = 3,
    parameter int TAGW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_en,
    input  logic [REGW-1:0] iss_dst,
    input  logic [REGW-1:0] iss_src1,
    input  logic [REGW-1:0] iss_src2,
    input  logic [TAGW-1:0] iss_q1,
    input  logic [TAGW-1:0] iss_q2,
    input  logic            ex_done,
    input  logic            wb_valid,
    input  logic [TAGW-1:0] wb_tag,
    input  logic            wb_grant,
    output logic            busy,
    output logic            done_ready,
    output logic            rd_grant,
    output logic [REGW-1:0] fi,
    output logic [REGW-1:0] fj,
    output logic [REGW-1:0] fk,
    output logic            rj,
    output logic            rk
);

    unit_state_e state, state_nx;
    logic [TAGW-1:0] qj, qk;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= U_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            U_IDLE:     if (iss_en)   state_nx = U_WAIT_OPS;  // T_ISSUE
            U_WAIT_OPS: if (rj && rk) state_nx = U_EXEC;      // T_READ
            U_EXEC:     if (ex_done)  state_nx = U_DONE;      // T_FINISH
            U_DONE:     if (wb_grant) state_nx = U_IDLE;      // T_RETIRE
            default:                  state_nx = U_IDLE;
        endcase
    end

    // Outputs decoded from the state and the ready flags
    always_comb begin
        busy       = (state != U_IDLE);
        rd_grant   = (state == U_WAIT_OPS) && rj && rk;
        done_ready = (state == U_DONE);
    end

    // Status record: register fields, producer tags, ready flags
    always_ff @(posedge clk) begin
        if (rst) begin
            fi <= '0;
            fj <= '0;
            fk <= '0;
            qj <= '0;
            qk <= '0;
            rj <= 1'b0;
            rk <= 1'b0;
        end else if (iss_en) begin
            fi <= iss_dst;
            fj <= iss_src1;
            fk <= iss_src2;
            qj <= iss_q1;
            qk <= iss_q2;
            rj <= (iss_q1 == '0);
            rk <= (iss_q2 == '0);
        end else begin
            if (rd_grant) begin
                rj <= 1'b0;
                rk <= 1'b0;
            end
            if (state == U_WAIT_OPS && wb_valid && !rj && qj == wb_tag) begin
                rj <= 1'b1;
                qj <= '0;
            end
            if (state == U_WAIT_OPS && wb_valid && !rk && qk == wb_tag) begin
                rk <= 1'b1;
                qk <= '0;
            end
        end
    end

    AST_READ_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
        rd_grant |=> (state == U_EXEC && !rj && !rk)); // R4

    AST_RETIRE_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_grant |-> (state == U_DONE)); // R5

    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
        wb_grant |=> !busy); // R9

    AST_ISSUE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        iss_en |-> (state == U_IDLE)); // R1

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int NUM_REQ = 4,
    localparam int IDXW   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] grant,
    output logic [IDXW-1:0]    idx,
    output logic               any
);

    // Fixed priority: lowest index wins
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDXW'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ooo_scoreboard.sv
module ooo_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int NUM_REGS  = 8,
    localparam int OPW      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int TAGW     = $clog2(NUM_UNITS + 1),
    localparam int REGW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [OPW-1:0]       iss_op,
    input  logic [REGW-1:0]      iss_dst,
    input  logic [REGW-1:0]      iss_src1,
    input  logic [REGW-1:0]      iss_src2,
    input  logic [NUM_UNITS-1:0] ex_done,
    output logic                 iss_accept,
    output logic [NUM_UNITS-1:0] rd_grant,
    output logic                 wb_valid,
    output logic [NUM_UNITS-1:0] wb_grant,
    output logic [REGW-1:0]      wb_dst
);

    logic [NUM_UNITS-1:0] unit_busy;
    logic [NUM_UNITS-1:0] unit_done;
    logic [NUM_UNITS-1:0] unit_rj;
    logic [NUM_UNITS-1:0] unit_rk;
    logic [NUM_UNITS-1:0] war_clear;
    logic [NUM_UNITS-1:0] wb_req;
    logic [NUM_UNITS-1:0] iss_en;
    logic [REGW-1:0]      fi_a [NUM_UNITS];
    logic [REGW-1:0]      fj_a [NUM_UNITS];
    logic [REGW-1:0]      fk_a [NUM_UNITS];
    logic [TAGW-1:0]      tag_s1, tag_s2, tag_dst;
    logic [TAGW-1:0]      q1_eff, q2_eff;
    logic [TAGW-1:0]      wb_tag;
    logic [OPW-1:0]       wb_idx;
    logic                 op_ok;

    // Issue condition: target unit free and destination not owned
    always_comb begin
        op_ok      = ({1'b0, iss_op} < (OPW+1)'(NUM_UNITS));
        iss_accept = iss_valid && op_ok && !unit_busy[iss_op] && (tag_dst == '0);
    end

    // Same-cycle wake-up bypass on the sources of the issuing instruction
    always_comb begin
        wb_tag = TAGW'(wb_idx) + TAGW'(1);
        q1_eff = tag_s1;
        q2_eff = tag_s2;
        if (wb_valid && tag_s1 == wb_tag) q1_eff = '0;
        if (wb_valid && tag_s2 == wb_tag) q2_eff = '0;
    end

    sb_result_table #(
        .NUM_REGS (NUM_REGS),
        .TAGW     (TAGW)
    ) u_result (
        .clk      (clk),
        .rst      (rst),
        .set_en   (iss_accept),
        .set_idx  (iss_dst),
        .set_tag  (TAGW'(iss_op) + TAGW'(1)),
        .clr_en   (wb_valid),
        .clr_idx  (wb_dst),
        .rd_idx_a (iss_src1),
        .rd_idx_b (iss_src2),
        .rd_idx_d (iss_dst),
        .rd_tag_a (tag_s1),
        .rd_tag_b (tag_s2),
        .rd_tag_d (tag_dst)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign iss_en[u] = iss_accept && (iss_op == OPW'(u));

        sb_unit #(
            .REGW (REGW),
            .TAGW (TAGW)
        ) u_unit (
            .clk        (clk),
            .rst        (rst),
            .iss_en     (iss_en[u]),
            .iss_dst    (iss_dst),
            .iss_src1   (iss_src1),
            .iss_src2   (iss_src2),
            .iss_q1     (q1_eff),
            .iss_q2     (q2_eff),
            .ex_done    (ex_done[u]),
            .wb_valid   (wb_valid),
            .wb_tag     (wb_tag),
            .wb_grant   (wb_grant[u]),
            .busy       (unit_busy[u]),
            .done_ready (unit_done[u]),
            .rd_grant   (rd_grant[u]),
            .fi         (fi_a[u]),
            .fj         (fj_a[u]),
            .fk         (fk_a[u]),
            .rj         (unit_rj[u]),
            .rk         (unit_rk[u])
        );

        // WAR clearance: nobody still needs the old value of this destination
        always_comb begin
            war_clear[u] = 1'b1;
            for (int f = 0; f < NUM_UNITS; f++) begin
                if ((fj_a[f] == fi_a[u] && unit_rj[f]) ||
                    (fk_a[f] == fi_a[u] && unit_rk[f])) begin
                    war_clear[u] = 1'b0;
                end
            end
        end

        assign wb_req[u] = unit_done[u] && war_clear[u];
    end

    sb_wb_arbiter #(
        .NUM_REQ (NUM_UNITS)
    ) u_arb (
        .req   (wb_req),
        .grant (wb_grant),
        .idx   (wb_idx),
        .any   (wb_valid)
    );

    assign wb_dst = fi_a[wb_idx];

    AST_ISSUE_CLAIMS: assert property (@(posedge clk) disable iff (rst)
        iss_accept |=> unit_busy[$past(iss_op)]); // R1

    AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant) && (wb_valid == (wb_grant != '0))); // R7

    AST_WB_FROM_FINISHED: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> unit_done[wb_idx]); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (unit_busy == '0 && unit_rj == '0 && unit_rk == '0)); // R10

endmodule

// File: tb/tb_ooo_scoreboard.sv
`timescale 1ns/1ps
module tb_ooo_scoreboard;

    localparam int N    = 4;
    localparam int NV   = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_op = '0;
    logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [N-1:0] ex_done = '0;
    logic       iss_accept;
    logic [N-1:0] rd_grant;
    logic       wb_valid;
    logic [N-1:0] wb_grant;
    logic [2:0] wb_dst;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ooo_scoreboard #(.NUM_UNITS(N), .NUM_REGS(8)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .ex_done(ex_done), .iss_accept(iss_accept), .rd_grant(rd_grant),
        .wb_valid(wb_valid), .wb_grant(wb_grant), .wb_dst(wb_dst)
    );

    // {valid, op, dst, src1, src2, done | acc, rd, wbv, wbdst, wbgrant}
    localparam logic [28:0] VEC [NV] = '{
        {1'b1,2'd0,3'd1,3'd2,3'd3,4'b0000, 1'b1,4'b0000,1'b0,3'd0,4'b0000},
        {1'b1,2'd1,3'd4,3'd1,3'd2,4'b0000, 1'b1,4'b0001,1'b0,3'd0,4'b0000},
        {1'b1,2'd2,3'd2,3'd5,3'd6,4'b0000, 1'b1,4'b0000,1'b0,3'd0,4'b0000},
        {1'b1,2'd3,3'd1,3'd4,3'd0,4'b0000, 1'b0,4'b0100,1'b0,3'd0,4'b0000},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0100, 1'b0,4'b0000,1'b0,3'd0,4'b0000},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0001, 1'b0,4'b0000,1'b0,3'd0,4'b0000},
        {1'b1,2'd3,3'd7,3'd1,3'd4,4'b0000, 1'b1,4'b0000,1'b1,3'd1,4'b0001},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0010,1'b0,3'd0,4'b0000},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0010, 1'b0,4'b0000,1'b1,3'd2,4'b0100},
        {1'b1,2'd0,3'd2,3'd4,3'd4,4'b0000, 1'b1,4'b0000,1'b1,3'd4,4'b0010},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b1001,1'b0,3'd0,4'b0000},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b1001, 1'b0,4'b0000,1'b0,3'd0,4'b0000},
        {1'b0,2'd0,3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,1'b1,3'd2,4'b0001},
        {1'b1,2'd3,3'd5,3'd0,3'd0,4'b0000, 1'b0,4'b0000,1'b1,3'd7,4'b1000},
        {1'b1,2'd0,3'd1,3'd1,3'd1,4'b0000, 1'b1,4'b0000,1'b0,3'd0,4'b0000}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [2:0] d,
                         input logic [2:0] a, input logic [2:0] b, input logic [3:0] dn);
        iss_valid = v; iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b; ex_done = dn;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 reset accept", 32'(iss_accept), 0);
        chk("R10 reset rd_grant", 32'(rd_grant), 0);
        chk("R10 reset wb_valid", 32'(wb_valid), 0);

        // Table walk: one entry per cycle
        for (int i = 0; i < NV; i++) begin
            logic [28:0] e;
            @(negedge clk);
            e = VEC[i];
            drive(e[28], e[27:26], e[25:23], e[22:20], e[19:17], e[16:13]);
            #1;
            chk($sformatf("R1 R2 R3 accept step %0d", i), 32'(iss_accept), 32'(e[12]));
            chk($sformatf("R3 R4 R8 rd_grant step %0d", i), 32'(rd_grant), 32'(e[11:8]));
            chk($sformatf("R5 R6 R7 wb_valid step %0d", i), 32'(wb_valid), 32'(e[7]));
            if (e[7]) begin
                chk($sformatf("R7 R9 wb_dst step %0d", i), 32'(wb_dst), 32'(e[6:4]));
            end
            chk($sformatf("R6 R7 wb_grant step %0d", i), 32'(wb_grant), 32'(e[3:0]));
        end

        // R10: reset mid-flight (unit 0 busy, r1 owned) frees everything
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1, 0, 1, 1, 1, 4'b0000);
        #1;
        chk("R10 accept after reset", 32'(iss_accept), 1);
        chk("R10 rd_grant after reset", 32'(rd_grant), 0);

        // R5: done pulse while still waiting for operands is ignored
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b1111);
        #1;
        chk("R4 rd_grant unit0", 32'(rd_grant), 32'b0001);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000);
        #1;
        chk("R5 early done ignored", 32'(wb_valid), 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0001);
        #1;
        chk("R5 no wb in done cycle", 32'(wb_valid), 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000);
        #1;
        chk("R7 wb_grant unit0", 32'(wb_grant), 32'b0001);
        chk("R7 wb_dst", 32'(wb_dst), 1);

        // R9: destination r1 released, another unit may now claim it
        @(negedge clk);
        drive(1, 1, 1, 0, 0, 4'b0000);
        #1;
        chk("R9 destination released", 32'(iss_accept), 1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule